// File: doc/BRIEF.md
# Interleaved Multichannel Running Accumulator

This block takes a stream of signed samples in which eight channels arrive in turn, one after another. The sample at stream position i belongs to channel i mod 8. The block keeps one running total per channel. For every sample it accepts, it returns that channel's total after the sample has been added.

The totals are never reset at a frame boundary, so they carry on from one frame to the next. A dedicated clear input is the only way to return every total to zero. A frame holds 400 samples per channel. An output-side counter raises a last marker on the final beat of each frame.

A build-time switch selects the datapath:
- **Serial mode** takes one sample per clock and uses one adder.
- **Parallel mode** takes a whole group of eight samples per clock, with lane k carrying channel k, and uses eight adders.

Both directions use a valid/ready handshake. Output backpressure stalls the input side without dropping or reordering data.

Top module: `interleaved_accum`

## Requirements
- R1: After reset, out_valid is 0, in_ready is 1 and every channel total is zero, so the first output of each channel equals its first sample.
- R2: In serial mode, the k-th accepted sample since reset (k counted from 0) belongs to channel k mod 8. out_chan carries that channel number with its output. In parallel mode out_chan is 0.
- R3: Each output equals the signed two's-complement sum of all samples accepted on that channel since reset or the last clear, including the current sample. Samples are sign-extended to DW+12 bits and the sum wraps at that width.
- R4: Channel totals carry across frame boundaries unchanged.
- R5: In serial mode, out_last is 1 only on the output of accepted beat k where k mod (8*FRAME_SAMPLES) = 8*FRAME_SAMPLES-1. In parallel mode the same rule applies with the frame length FRAME_SAMPLES groups.
- R6: While clr_i is 1, all eight totals become zero at the next clock edge, in_ready is 0 so no sample is consumed, and an output already held in the output register keeps its value.
- R7: While out_valid is 1 and out_ready is 0, out_data, out_last and out_chan hold steady and in_ready is 0. Every accepted beat appears at the output exactly once, in acceptance order.
- R8: With clr_i at 0, in_ready equals (not out_valid) or out_ready. A continuously fed stream with out_ready at 1 moves one beat per clock, and each accepted beat is presented on the output in the cycle after acceptance.
- R9: In parallel mode, lane k of in_data (bits k*16 and up) adds into channel k, and lane k of out_data (bits k*28 and up) returns channel k's total. All eight totals update on the same accepted beat.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear of all channel totals |
| in_valid | input | 1 | Input beat offered |
| in_ready | output | 1 | Block can take the offered beat |
| in_data | input | LANES*DW | One sample (serial) or eight lanes (parallel), signed |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Consumer takes the output beat |
| out_data | output | LANES*(DW+12) | Updated channel total(s) |
| out_last | output | 1 | Final beat of a frame |
| out_chan | output | 3 | Channel of the serial output; 0 in parallel mode |

## Verification
A clear request and an offered sample can fall in the same cycle, and each may also meet an output that is stalled by backpressure. The bench raises clr_i while a sample is held on the input and an unread total sits in the output register. It then judges four things:
- in_ready stays low during the clear.
- The held output keeps its value.
- The sample is taken only afterwards.
- The sample's output equals the bare sample value, because its channel has been zeroed.

A reference model, updated from the observed handshakes, checks every serial output for value, channel and last marker.

// File: rtl/mca_pkg.sv
package mca_pkg;

  typedef enum logic {
    MODE_SERIAL   = 1'b0,
    MODE_PARALLEL = 1'b1
  } mca_mode_e;

  // next value of a wrapping counter that runs 0..top
  function automatic int unsigned wrap_next(input int unsigned cur, input int unsigned top);
    return (cur >= top) ? 0 : cur + 1;
  endfunction

  // beats per frame: one group per beat in parallel, one sample per beat in serial
  function automatic int unsigned frame_beats(input int unsigned samples_per_ch,
                                              input int unsigned channels,
                                              input mca_mode_e   mode);
    return (mode == MODE_PARALLEL) ? samples_per_ch : samples_per_ch * channels;
  endfunction

  function automatic int unsigned safe_clog2(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/mca_beat_tracker.sv
module mca_beat_tracker #(
  parameter int CH         = 8,
  parameter int CW         = 3,
  parameter int BEATS      = 3200,
  parameter int BW         = 12,
  parameter bit SERIAL_IDX = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  output logic [CW-1:0] chan_idx,
  output logic          frame_end
);

  logic [BW-1:0] beat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_q <= '0;
    end else if (adv) begin
      beat_q <= BW'(mca_pkg::wrap_next(32'(beat_q), BEATS - 1));
    end
  end

  assign frame_end = (beat_q == BW'(BEATS - 1));

  generate
    if (SERIAL_IDX) begin : g_rr
      logic [CW-1:0] chan_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          chan_q <= '0;
        end else if (adv) begin
          chan_q <= CW'(mca_pkg::wrap_next(32'(chan_q), CH - 1));
        end
      end
      assign chan_idx = chan_q;
    end else begin : g_fixed
      assign chan_idx = '0;
    end
  endgenerate

endmodule

// File: rtl/mca_acc_bank.sv
module mca_acc_bank #(
  parameter int CH     = 8,
  parameter int CW     = 3,
  parameter int DW     = 16,
  parameter int AW     = 28,
  parameter int LANES  = 1,
  parameter bit SERIAL = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                upd,
  input  logic [CW-1:0]       chan_idx,
  input  logic [LANES*DW-1:0] samples,
  output logic [LANES*AW-1:0] sums_nx
);

  localparam int EXT = AW - DW;

  // sign-extend a sample and add it to a running total (wraps at AW bits)
  function automatic logic [AW-1:0] add_sample(input logic [AW-1:0] base,
                                               input logic [DW-1:0] smp);
    return base + {{EXT{smp[DW-1]}}, smp};
  endfunction

  logic [CH*AW-1:0] acc_flat;
  logic [CH-1:0]    wr_en;
  logic [CH*AW-1:0] wr_val;

  generate
    if (SERIAL) begin : g_serial
      logic [AW-1:0] sel_acc;
      logic [AW-1:0] sel_sum;
      always_comb begin
        sel_acc = acc_flat[chan_idx*AW +: AW];
        sel_sum = add_sample(sel_acc, samples[DW-1:0]);
      end
      assign sums_nx = sel_sum;
      for (genvar c = 0; c < CH; c++) begin : g_sel
        assign wr_en[c]              = upd && (chan_idx == CW'(c));
        assign wr_val[c*AW +: AW]    = sel_sum;
      end
    end else begin : g_parallel
      for (genvar k = 0; k < CH; k++) begin : g_lane
        assign sums_nx[k*AW +: AW] = add_sample(acc_flat[k*AW +: AW], samples[k*DW +: DW]);
        assign wr_en[k]            = upd;
        assign wr_val[k*AW +: AW]  = sums_nx[k*AW +: AW];
      end
    end
  endgenerate

  for (genvar c = 0; c < CH; c++) begin : g_ch
    logic [AW-1:0] acc_r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        acc_r <= '0;
      end else if (clr) begin
        acc_r <= '0;
      end else if (wr_en[c]) begin
        acc_r <= wr_val[c*AW +: AW];
      end
    end
    assign acc_flat[c*AW +: AW] = acc_r;
  end

endmodule

// File: rtl/mca_out_stage.sv
module mca_out_stage #(
  parameter int OW = 28,
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [OW-1:0] load_data,
  input  logic          load_last,
  input  logic [CW-1:0] load_chan,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [OW-1:0] out_data,
  output logic          out_last,
  output logic [CW-1:0] out_chan,
  output logic          room
);

  assign room = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else if (load) begin
      out_valid <= 1'b1;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_data <= '0;
      out_last <= 1'b0;
      out_chan <= '0;
    end else if (load) begin
      out_data <= load_data;
      out_last <= load_last;
      out_chan <= load_chan;
    end
  end

endmodule

// File: rtl/interleaved_accum.sv
module interleaved_accum #(
  parameter int CH            = 8,
  parameter int DW            = 16,
  parameter int GUARD         = 12,
  parameter int FRAME_SAMPLES = 400,
  parameter bit PARALLEL      = 1'b0
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          clr_i,
  input  logic                          in_valid,
  output logic                          in_ready,
  input  logic [(PARALLEL ? CH : 1)*DW-1:0]            in_data,
  output logic                          out_valid,
  input  logic                          out_ready,
  output logic [(PARALLEL ? CH : 1)*(DW+GUARD)-1:0]    out_data,
  output logic                          out_last,
  output logic [mca_pkg::safe_clog2(CH)-1:0]           out_chan
);

  import mca_pkg::*;

  localparam mca_mode_e MODE  = PARALLEL ? MODE_PARALLEL : MODE_SERIAL;
  localparam int        LANES = (MODE == MODE_PARALLEL) ? CH : 1;
  localparam int        CW    = safe_clog2(CH);
  localparam int        AW    = DW + GUARD;
  localparam int        OW    = LANES * AW;
  localparam int        BEATS = frame_beats(FRAME_SAMPLES, CH, MODE);
  localparam int        BW    = safe_clog2(BEATS);

  // named internal events
  logic          room;
  logic          accept;
  logic          emit;
  logic          frame_end;
  logic [CW-1:0] chan_idx;
  logic [OW-1:0] sums_nx;

  assign in_ready = room && !clr_i;
  assign accept   = in_valid && in_ready;
  assign emit     = out_valid && out_ready;

  mca_beat_tracker #(
    .CH        (CH),
    .CW        (CW),
    .BEATS     (BEATS),
    .BW        (BW),
    .SERIAL_IDX(MODE == MODE_SERIAL)
  ) u_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv      (accept),
    .chan_idx (chan_idx),
    .frame_end(frame_end)
  );

  mca_acc_bank #(
    .CH    (CH),
    .CW    (CW),
    .DW    (DW),
    .AW    (AW),
    .LANES (LANES),
    .SERIAL(MODE == MODE_SERIAL)
  ) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr_i),
    .upd     (accept),
    .chan_idx(chan_idx),
    .samples (in_data),
    .sums_nx (sums_nx)
  );

  mca_out_stage #(
    .OW(OW),
    .CW(CW)
  ) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .load_data(sums_nx),
    .load_last(frame_end),
    .load_chan(chan_idx),
    .out_ready(out_ready),
    .out_valid(out_valid),
    .out_data (out_data),
    .out_last (out_last),
    .out_chan (out_chan),
    .room     (room)
  );

endmodule

// File: rtl/mca_checker.sv
module mca_checker #(
  parameter int OW = 28,
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clr_i,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [OW-1:0] out_data,
  input logic          out_last,
  input logic [CW-1:0] out_chan,
  input logic          accept,
  input logic          emit
);

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last) && $stable(out_chan));

  // R7
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  // R6
  clear_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |-> !in_ready);

  // R8
  ready_when_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid && !clr_i |-> in_ready);

  // R8
  accept_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);

  // R7
  drain_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    emit && !accept |=> !out_valid);

  // R1
  idle_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> !accept);

endmodule

bind interleaved_accum mca_checker #(.OW(OW), .CW(CW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .clr_i    (clr_i),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_data (out_data),
  .out_last (out_last),
  .out_chan (out_chan),
  .accept   (accept),
  .emit     (emit)
);

// File: tb/interleaved_accum_tb.sv
`timescale 1ns/1ps
module interleaved_accum_tb;

  localparam int DW = 16;
  localparam int AW = 28;
  localparam int CH = 8;
  localparam int SF = 3200;   // serial beats per frame
  localparam int PF = 5;      // parallel frame length in groups

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  int  tests = 0;
  int  fails = 0;
  bit  done  = 1'b0;
  int  cyc   = 0;
  always @(posedge clk) cyc++;

  logic rst_n;

  // serial instance
  logic          s_clr, s_iv, s_ir, s_ov, s_or, s_ol;
  logic [DW-1:0] s_id;
  logic [AW-1:0] s_od;
  logic [2:0]    s_oc;

  // parallel instance
  logic             p_clr, p_iv, p_ir, p_ov, p_or, p_ol;
  logic [CH*DW-1:0] p_id;
  logic [CH*AW-1:0] p_od;
  logic [2:0]       p_oc;

  interleaved_accum u_dut (
    .clk(clk), .rst_n(rst_n), .clr_i(s_clr), .in_valid(s_iv), .in_ready(s_ir),
    .in_data(s_id), .out_valid(s_ov), .out_ready(s_or), .out_data(s_od),
    .out_last(s_ol), .out_chan(s_oc)
  );

  interleaved_accum #(.FRAME_SAMPLES(PF), .PARALLEL(1'b1)) u_dut_par (
    .clk(clk), .rst_n(rst_n), .clr_i(p_clr), .in_valid(p_iv), .in_ready(p_ir),
    .in_data(p_id), .out_valid(p_ov), .out_ready(p_or), .out_data(p_od),
    .out_last(p_ol), .out_chan(p_oc)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // ---------------- serial reference model, driven by observed handshakes
  longint        s_acc [CH];
  int            s_idx      = 0;
  int            s_last_cnt = 0;
  logic [AW-1:0] s_last_out = '0;
  logic [AW-1:0] q_sum [$];
  int            q_ch  [$];
  bit            q_last[$];

  always @(negedge clk) begin
    int            c;
    logic [AW-1:0] e;
    if (rst_n && !done) begin
      if (s_clr) begin
        for (int k = 0; k < CH; k++) s_acc[k] = 0;
      end else if (s_iv && s_ir) begin
        c = s_idx % CH;
        s_acc[c] = s_acc[c] + longint'($signed(s_id));
        e = s_acc[c][AW-1:0];
        q_sum.push_back(e);
        q_ch.push_back(c);
        q_last.push_back((s_idx % SF) == SF - 1);
        s_idx++;
      end
      if (s_ov && s_or) begin
        if (q_sum.size() == 0) begin
          chk(1'b0, "R7", "output without accepted input", 1, 0);
        end else begin
          logic [AW-1:0] es;
          int            ec;
          bit            el;
          es = q_sum.pop_front();
          ec = q_ch.pop_front();
          el = q_last.pop_front();
          chk(s_od == es, "R3", "serial running sum", longint'(s_od), longint'(es));
          chk(int'(s_oc) == ec, "R2", "serial channel", longint'(s_oc), longint'(ec));
          chk(s_ol == el, "R5", "serial last marker", longint'(s_ol), longint'(el));
          if (s_ol) s_last_cnt++;
          s_last_out = s_od;
        end
      end
    end
  end

  task automatic send_s(input logic [DW-1:0] v);
    s_iv = 1'b1;
    s_id = v;
    @(negedge clk);
    while (!s_ir) @(negedge clk);
    @(posedge clk); #1;
    s_iv = 1'b0;
  endtask

  task automatic drain_s();
    s_iv = 1'b0;
    s_or = 1'b1;
    repeat (3) @(posedge clk);
    #1;
  endtask

  // ---------------- parallel reference model
  longint p_acc [CH];
  int     p_beat = 0;

  task automatic send_p(input int base, input string tag);
    logic [DW-1:0] lane;
    logic [AW-1:0] e;
    for (int k = 0; k < CH; k++) p_id[k*DW +: DW] = DW'(base * (k + 1) - 300 * k);
    p_iv = 1'b1;
    @(negedge clk);
    chk(p_ir == 1'b1, "R8", "parallel ready with free output", longint'(p_ir), 1);
    @(posedge clk); #1;
    p_iv = 1'b0;
    for (int k = 0; k < CH; k++) begin
      lane     = p_id[k*DW +: DW];
      p_acc[k] = p_acc[k] + longint'($signed(lane));
      e        = p_acc[k][AW-1:0];
      chk(p_od[k*AW +: AW] == e, tag, $sformatf("parallel lane %0d sum", k),
          longint'(p_od[k*AW +: AW]), longint'(e));
    end
    chk(p_ov == 1'b1, "R8", "parallel output valid next cycle", longint'(p_ov), 1);
    chk(p_ol == ((p_beat % PF) == PF - 1), "R5", "parallel last marker",
        longint'(p_ol), longint'((p_beat % PF) == PF - 1));
    chk(p_oc == 3'd0, "R2", "parallel channel field", longint'(p_oc), 0);
    p_beat++;
  endtask

  // ---------------- scenarios
  task automatic t_reset();
    @(negedge clk);
    chk(s_ov == 1'b0, "R1", "serial out_valid after reset", longint'(s_ov), 0);
    chk(s_ir == 1'b1, "R1", "serial in_ready after reset", longint'(s_ir), 1);
    chk(p_ov == 1'b0, "R1", "parallel out_valid after reset", longint'(p_ov), 0);
    chk(p_ir == 1'b1, "R1", "parallel in_ready after reset", longint'(p_ir), 1);
    @(posedge clk); #1;
  endtask

  task automatic t_frame();
    int t0;
    s_or = 1'b1;
    t0   = cyc;
    for (int i = 0; i < SF; i++) send_s(DW'((i * 977) ^ (i << 5)));
    chk((cyc - t0) == SF, "R8", "one beat per clock over a frame", longint'(cyc - t0), SF);
    drain_s();
    chk(q_sum.size() == 0, "R7", "all frame outputs delivered", q_sum.size(), 0);
    chk(s_last_cnt == 1, "R5", "one last marker per frame", s_last_cnt, 1);
  endtask

  task automatic t_persist();
    // R4: totals continue from the previous frame; scoreboard checks each value
    for (int i = 0; i < 2 * CH; i++) send_s(DW'(11 * i - 40));
    drain_s();
    chk(q_sum.size() == 0, "R4", "carry-over outputs delivered", q_sum.size(), 0);
  endtask

  task automatic t_extremes();
    for (int i = 0; i < CH; i++) send_s(16'h8000);
    for (int i = 0; i < CH; i++) send_s(16'h7FFF);
    drain_s();
    chk(q_sum.size() == 0, "R3", "extreme-value outputs delivered", q_sum.size(), 0);
  endtask

  task automatic t_backpressure();
    logic [AW-1:0] held;
    s_or = 1'b0;
    send_s(16'd1234);
    s_iv = 1'b1;
    s_id = 16'd77;
    @(negedge clk);
    held = s_od;
    for (int i = 0; i < 3; i++) begin
      chk(s_ir == 1'b0, "R7", "in_ready low while stalled", longint'(s_ir), 0);
      chk(s_od == held, "R7", "held output stable", longint'(s_od), longint'(held));
      chk(s_ov == 1'b1, "R7", "output stays valid", longint'(s_ov), 1);
      @(negedge clk);
    end
    @(posedge clk); #1;
    s_or = 1'b1;
    @(negedge clk);
    while (!s_ir) @(negedge clk);
    @(posedge clk); #1;
    s_iv = 1'b0;
    drain_s();
    chk(q_sum.size() == 0, "R7", "no beat lost under backpressure", q_sum.size(), 0);
  endtask

  task automatic t_clear();
    s_or  = 1'b1;
    s_iv  = 1'b1;
    s_id  = 16'd5;
    s_clr = 1'b1;
    @(negedge clk);
    chk(s_ir == 1'b0, "R6", "in_ready low during clear", longint'(s_ir), 0);
    @(posedge clk); #1;
    s_clr = 1'b0;
    @(negedge clk);
    while (!s_ir) @(negedge clk);
    @(posedge clk); #1;
    s_iv = 1'b0;
    drain_s();
    chk(s_last_out == AW'(5), "R6", "first sum after clear", longint'(s_last_out), 5);
    for (int i = 0; i < CH; i++) send_s(16'd3);
    drain_s();
  endtask

  task automatic t_clear_pending();
    logic [AW-1:0] pend;
    s_or = 1'b0;
    send_s(16'd100);
    s_clr = 1'b1;
    s_iv  = 1'b1;
    s_id  = 16'd7;
    @(negedge clk);
    pend = s_od;
    chk(s_ir == 1'b0, "R6", "clear with stalled output blocks input", longint'(s_ir), 0);
    @(posedge clk); #1;
    s_clr = 1'b0;
    @(negedge clk);
    chk(s_od == pend, "R6", "pending output untouched by clear", longint'(s_od), longint'(pend));
    chk(s_ir == 1'b0, "R7", "still stalled after clear", longint'(s_ir), 0);
    @(posedge clk); #1;
    s_or = 1'b1;
    @(negedge clk);
    while (!s_ir) @(negedge clk);
    @(posedge clk); #1;
    s_iv = 1'b0;
    drain_s();
    chk(s_last_out == AW'(7), "R6", "sample after clear starts from zero", longint'(s_last_out), 7);
    chk(q_sum.size() == 0, "R7", "collision beats delivered", q_sum.size(), 0);
  endtask

  task automatic t_parallel();
    p_or = 1'b1;
    for (int g = 0; g < 12; g++) send_p(123 * g - 700, "R9");
    p_clr = 1'b1;
    @(negedge clk);
    chk(p_ir == 1'b0, "R6", "parallel in_ready low during clear", longint'(p_ir), 0);
    @(posedge clk); #1;
    p_clr = 1'b0;
    for (int k = 0; k < CH; k++) p_acc[k] = 0;
    send_p(9, "R6");
    send_p(-20000, "R3");
  endtask

  initial begin
    rst_n = 1'b0;
    s_clr = 1'b0; s_iv = 1'b0; s_id = '0; s_or = 1'b1;
    p_clr = 1'b0; p_iv = 1'b0; p_id = '0; p_or = 1'b1;
    for (int k = 0; k < CH; k++) begin
      s_acc[k] = 0;
      p_acc[k] = 0;
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_frame();
    t_persist();
    t_extremes();
    t_backpressure();
    t_clear();
    t_clear_pending();
    t_parallel();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #900us;
    if (!done) begin
      done = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog: run did not complete");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule